// File: doc/BRIEF.md
# Legacy NMI Status and Control Port

This block is one byte-wide register at a fixed I/O address. It collects two legacy non-maskable interrupt sources, a system-error event line and an I/O-check event line. Each source has its own sticky status bit and its own disable-and-clear control bit. The same byte shows the live level of an external interval-timer channel-2 output. It also shows a bit that inverts at the legacy memory-refresh interval of 15 µs, even though no refresh is ever performed. The two lowest control bits gate timer channel 2 and pass its output to the speaker pin.

Software reads the byte to find which source raised the NMI. To acknowledge a source, software writes 1 to that source's control bit and then writes 0 to it again. While the control bit is 1, the status bit is held at 0. An event line is edge-sensitive. A level that stays high across the acknowledge does not latch again. Only a fresh rising edge after re-enabling sets the bit again.

The asynchronous reset is released through a two-stage synchronizer. Register state therefore starts to move on the third clock edge after `rst_n` goes high.

Top module: `legacy_nmi_port`

## Requirements
- R1: While in reset, and at reset release, every register bit is 0. `nmi_req`, `tmr2_gate` and `spkr_out` are 0, and `rdata` shows only the live timer level in bit 5.
- R2: Bit 7 (system-error status) becomes 1 on the edge that samples a rising edge of `serr_evt` while bit 2 is 0 after that edge. It then stays 1 until bit 2 is written to 1.
- R3: Bit 6 (I/O-check status) behaves the same way with `iochk_evt` and control bit 3.
- R4: Writing 1 to bit 2 or bit 3 clears the matching status bit on that same write edge. It also blocks any new event while the bit is 1. After the bit is written back to 0, an event line that stayed high does not set the status. Only a new rising edge does.
- R5: Bit 5 of `rdata` equals the `tmr2_out` input combinationally.
- R6: Bit 4 inverts once every TC+1 clock cycles and is 0 at reset release. TC = CLK_HZ·REFRESH_NS/10^9 − 1, which gives 1499 for 100 MHz and 15000 ns.
- R7: Bits 3..0 are read-write. A write with `wr_en` high and `addr` equal to REG_ADDR loads `wdata[3:0]` on that clock edge, and the new value reads back from the next cycle onward.
- R8: Values written to bits 7..4 have no effect on the register.
- R9: `spkr_out` is 0 while bit 1 is 0. While bit 1 is 1, it equals `tmr2_out`.
- R10: `tmr2_gate` equals bit 0.
- R11: `nmi_req` is 1 exactly while bit 7 or bit 6 is 1.
- R12: When `addr` differs from REG_ADDR, `rdata` is 0 and a write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | I/O address of the access |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| serr_evt | input | 1 | System-error event line |
| iochk_evt | input | 1 | I/O-check event line |
| tmr2_out | input | 1 | Timer channel-2 output level |
| spkr_out | output | 1 | Gated speaker data |
| tmr2_gate | output | 1 | Timer channel-2 count gate |
| nmi_req | output | 1 | NMI request, high while a status bit is set |

## Verification
Bits 5, the speaker output and the read multiplexer are combinational, so they are due in the same cycle as the stimulus. A write, or an event edge, shows in `rdata`, `nmi_req` and `tmr2_gate` one clock edge later. The refresh bit moves every 1500 edges, counted from the third edge after reset release. The bench drives inputs on the falling edge. Its reference model updates on the rising edge, and all outputs are compared 3 ns after that edge, where every one of these results has settled. The directed checks read at the falling edge that follows a stimulus.

// File: rtl/nmi_port_pkg.sv
package nmi_port_pkg;
  localparam int CTL_W         = 4;
  localparam int NSRC          = 2;
  localparam int GATE_BIT      = 0;
  localparam int SPK_BIT       = 1;
  localparam int DIS_BASE_BIT  = 2;   // bit 2 = system-error disable, bit 3 = I/O-check disable

  typedef struct packed {
    logic             serr_st;
    logic             iochk_st;
    logic             tmr_lvl;
    logic             ref_tog;
    logic [CTL_W-1:0] ctl;
  } nmi_byte_t;
endpackage

// File: rtl/nmi_rst_sync.sv
module nmi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/nmi_refresh_tick.sv
module nmi_refresh_tick #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int PERIOD_NS = 15_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tog_o
);
  localparam longint TC_L  = (longint'(CLK_HZ) * longint'(PERIOD_NS)) / 64'd1_000_000_000 - 64'd1;
  localparam int     TC    = int'(TC_L);
  localparam int     CNT_W = (TC > 0) ? $clog2(TC + 1) : 1;
  localparam logic [CNT_W-1:0] TC_V = CNT_W'(TC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tog_q, tog_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == TC_V);
    cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
    tog_d = tog_q ^ wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tog_q <= tog_d;
    end
  end

  assign tog_o = tog_q;

  // R6: the bit only moves on the cycle the divider restarts
  a_r6_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_q != $past(tog_q)) |-> (cnt_q == '0));
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TC_V);
endmodule

// File: rtl/nmi_src_latch.sv
module nmi_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic dis_nxt_i,
  output logic st_o
);
  logic evt_q, st_q, st_d, rise;

  always_comb begin
    rise = evt_i & ~evt_q;
    st_d = dis_nxt_i ? 1'b0 : (st_q | rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      evt_q <= evt_i;
      st_q  <= st_d;
    end
  end

  assign st_o = st_q;

  // R2, R3: sticky while the source stays enabled
  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q && !dis_nxt_i) |=> st_q);
  // R4: only a fresh rising edge can set the bit
  a_r4_set_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q) |-> $past(evt_i && !evt_q));
  a_r4_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dis_nxt_i |=> !st_q);
endmodule

// File: rtl/legacy_nmi_port.sv
module legacy_nmi_port
  import nmi_port_pkg::*;
#(
  parameter int          CLK_HZ     = 100_000_000,
  parameter int          REFRESH_NS = 15_000,
  parameter int          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              serr_evt,
  input  logic              iochk_evt,
  input  logic              tmr2_out,
  output logic              spkr_out,
  output logic              tmr2_gate,
  output logic              nmi_req
);
  logic             rst_int_n;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             hit, wr_hit;
  logic [NSRC-1:0]  evt, dis_nxt, st;
  logic             tog;
  nmi_byte_t        rd_word;
  logic             wdata_unused;

  nmi_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  nmi_refresh_tick #(.CLK_HZ(CLK_HZ), .PERIOD_NS(REFRESH_NS)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .tog_o(tog)
  );

  // control byte, next state then register
  always_comb begin
    hit    = (addr == REG_ADDR);
    wr_hit = wr_en & hit;
    ctl_d  = wr_hit ? wdata[CTL_W-1:0] : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ctl_q <= '0;
    else            ctl_q <= ctl_d;
  end

  assign wdata_unused = &{1'b0, wdata[7:CTL_W]};

  // source 0 = system error, source 1 = I/O check
  assign evt = {iochk_evt, serr_evt};

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign dis_nxt[i] = ctl_d[DIS_BASE_BIT + i];
      nmi_src_latch u_latch (
        .clk(clk), .rst_n(rst_int_n), .evt_i(evt[i]),
        .dis_nxt_i(dis_nxt[i]), .st_o(st[i])
      );
    end
  endgenerate

  always_comb begin
    rd_word.serr_st  = st[0];
    rd_word.iochk_st = st[1];
    rd_word.tmr_lvl  = tmr2_out;
    rd_word.ref_tog  = tog;
    rd_word.ctl      = ctl_q;
    rdata            = hit ? rd_word : '0;
  end

  assign spkr_out  = ctl_q[SPK_BIT] & tmr2_out;
  assign tmr2_gate = ctl_q[GATE_BIT];
  assign nmi_req   = |st;

  // R7: a matching write lands on the next edge
  a_r7_write_loads: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_hit |=> (ctl_q == $past(wdata[CTL_W-1:0])));
  // R12: without a matching write the control bits hold
  a_r12_no_stray_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_hit |=> $stable(ctl_q));
  // R2 / R3: a disabled source never shows status
  a_r2_serr_held_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctl_q[DIS_BASE_BIT] |-> !rd_word.serr_st);
  a_r3_iochk_held_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctl_q[DIS_BASE_BIT+1] |-> !rd_word.iochk_st);
  // R9: speaker silent unless enabled
  a_r9_spkr_gated: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctl_q[SPK_BIT] |-> !spkr_out);
endmodule

// File: tb/tb_legacy_nmi_port.sv
module tb_legacy_nmi_port;
  localparam int TB_TC = 100_000_000 / 1_000_000 * 15 - 1;  // 1499
  localparam logic [7:0] A_HIT = 8'h61;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr, wdata, rdata;
  logic       wr_en, serr_evt, iochk_evt, tmr2_out;
  logic       spkr_out, tmr2_gate, nmi_req;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  legacy_nmi_port dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .serr_evt(serr_evt), .iochk_evt(iochk_evt),
    .tmr2_out(tmr2_out), .spkr_out(spkr_out), .tmr2_gate(tmr2_gate),
    .nmi_req(nmi_req)
  );

  // behavioural reference model
  logic [3:0] m_ctl;
  bit m_s7, m_s6, m_pserr, m_piochk, m_tog;
  int m_cnt, m_sync;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = '0; m_s7 = 0; m_s6 = 0; m_pserr = 0; m_piochk = 0;
      m_tog = 0; m_cnt = 0; m_sync = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      logic [3:0] nc;
      nc = (wr_en && addr == A_HIT) ? wdata[3:0] : m_ctl;
      if (nc[2]) m_s7 = 0; else if (serr_evt && !m_pserr) m_s7 = 1;
      if (nc[3]) m_s6 = 0; else if (iochk_evt && !m_piochk) m_s6 = 1;
      m_pserr = serr_evt; m_piochk = iochk_evt;
      if (m_cnt == TB_TC) begin m_cnt = 0; m_tog = !m_tog; end else m_cnt++;
      m_ctl = nc;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 3 ns after the rising edge
  always begin
    @(posedge clk); #3;
    if (!done) begin
      logic [7:0] er;
      er = (addr == A_HIT) ? {m_s7, m_s6, tmr2_out, m_tog, m_ctl} : 8'h00;
      check("R2 bit7",    {7'd0, rdata[7]}, {7'd0, er[7]});
      check("R3 bit6",    {7'd0, rdata[6]}, {7'd0, er[6]});
      check("R5 bit5",    {7'd0, rdata[5]}, {7'd0, er[5]});
      check("R6 bit4",    {7'd0, rdata[4]}, {7'd0, er[4]});
      check("R7 ctl",     {4'd0, rdata[3:0]}, {4'd0, er[3:0]});
      check("R9 spkr",    {7'd0, spkr_out}, {7'd0, m_ctl[1] & tmr2_out});
      check("R10 gate",   {7'd0, tmr2_gate}, {7'd0, m_ctl[0]});
      check("R11 nmi",    {7'd0, nmi_req}, {7'd0, m_s7 | m_s6});
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = A_HIT;
  endtask

  task automatic pulse_serr();
    @(negedge clk); serr_evt = 1'b1;
    @(negedge clk); serr_evt = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; addr = A_HIT; wdata = '0; wr_en = 1'b0;
    serr_evt = 0; iochk_evt = 0; tmr2_out = 0;
    cyc(5);
    check("R1 reset rdata", rdata, 8'h00);
    check("R1 reset outs", {5'd0, nmi_req, tmr2_gate, spkr_out}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    cyc(4);
    check("R1 released", rdata, 8'h00);

    // speaker, gate and live timer level
    wr(A_HIT, 8'h03);
    @(negedge clk); tmr2_out = 1'b1; #1;
    check("R5 live timer", {7'd0, rdata[5]}, 8'h01);
    check("R9 spkr follows", {7'd0, spkr_out}, 8'h01);
    check("R10 gate on", {7'd0, tmr2_gate}, 8'h01);
    wr(A_HIT, 8'h01); #1;
    check("R9 spkr off", {7'd0, spkr_out}, 8'h00);
    tmr2_out = 1'b0;

    // R8: upper write bits ignored
    wr(A_HIT, 8'hF0); #1;
    check("R8 upper ignored", rdata & 8'hCF, 8'h00);

    // R2: sticky system error
    pulse_serr(); #1;
    check("R2 serr set", {7'd0, rdata[7]}, 8'h01);
    check("R11 nmi up", {7'd0, nmi_req}, 8'h01);
    cyc(3);
    check("R2 serr sticky", {7'd0, rdata[7]}, 8'h01);

    // R3: I/O check, line held high
    @(negedge clk); iochk_evt = 1'b1;
    @(negedge clk);
    check("R3 iochk set", {7'd0, rdata[6]}, 8'h01);
    wr(A_HIT, 8'h08); #1;
    check("R4 iochk cleared", {7'd0, rdata[6]}, 8'h00);
    check("R4 serr untouched", {7'd0, rdata[7]}, 8'h01);
    wr(A_HIT, 8'h00); cyc(2);
    check("R4 held level no reset", {7'd0, rdata[6]}, 8'h00);
    @(negedge clk); iochk_evt = 1'b0;
    @(negedge clk); iochk_evt = 1'b1;
    @(negedge clk);
    check("R3 new edge sets", {7'd0, rdata[6]}, 8'h01);
    iochk_evt = 1'b0;

    // R4: disabled serr blocks events
    wr(A_HIT, 8'h04);
    pulse_serr(); #1;
    check("R4 serr blocked", {7'd0, rdata[7]}, 8'h00);
    wr(A_HIT, 8'h0C); wr(A_HIT, 8'h00); cyc(2);
    check("R11 nmi down", {7'd0, nmi_req}, 8'h00);

    // R12: foreign address
    wr(8'h60, 8'h0F);
    @(negedge clk); addr = 8'h60; #1;
    check("R12 rdata zero", rdata, 8'h00);
    addr = A_HIT; #1;
    check("R12 write ignored", {4'd0, rdata[3:0]}, 8'h00);

    // R7: read back
    wr(A_HIT, 8'h0A); #1;
    check("R7 readback", {4'd0, rdata[3:0]}, 8'h0A);

    // R6: measure refresh period
    begin
      logic last;
      int n = 0;
      bit seen = 0;
      last = rdata[4];
      for (int i = 0; i < 4000; i++) begin
        @(negedge clk);
        if (seen) n++;
        if (rdata[4] != last) begin
          last = rdata[4];
          if (seen) break;
          seen = 1;
        end
      end
      check("R6 period", n[7:0], 8'((TB_TC + 1) & 255));
      tests++;
      if (n != TB_TC + 1) begin
        fails++;
        $display("FAIL R6 period cycles: actual %0d expected %0d", n, TB_TC + 1);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule